// File: doc/BRIEF.md
# PHY Tuning Control and Status Register

This block is a single 32-bit control and status word for a static read-capture PHY. It sits on a plain write-strobe bus with a combinational read-back. It drives the tuning outputs of the PHY: a read-enable delay count, a flag that picks the rising or falling capture edge, and a half-cycle swap of double-rate read data. Those tuning values, and the phase-step direction bit, are loaded with defaults only during the very first reset. Every later reset leaves them as they are, so a calibrated setting survives a controller restart.

Software moves the clock phase one tap at a time. A write with the request bit set sends a one-cycle enable, with a direction, to an external phase shifter. The shifter's done pulse sets a completion flag and moves a signed 10-bit tap counter by one. The counter saturates at its limits and is read back sign-extended to 16 bits. A new step is refused until the completion flag has been cleared by software. The block also contains a delay line that retards the incoming read-enable pulse by the programmed number of cycles before it goes to the read FIFOs.

Field positions use a numbering in which field bit k sits on bus bit 31−k. The bus positions listed below are the ones the block decodes.

Top module: `phy_tune_csr`

## Requirements
- R1: Read-back layout. Bus bits 31:28 hold the read-enable delay, with bit 31 as its MSB. Bit 27 is the capture edge (1 = rising, 0 = falling). Bit 26 is the half-cycle swap. Bit 24 is the first-reset flag. Bit 23 shows the phase-step enable. Bit 22 is the step direction (1 = increment, 0 = decrement). Bit 21 is the step-complete flag. Bit 20 is the initialization-done flag. Bits 15:0 hold the tap offset, sign-extended from 10 bits. Bits 25 and 19:16 always read 0.
- R2: During the first reset the delay, edge and swap fields take their parameter defaults (5, 1, 0) and bit 24 reads 0. From the first clock edge with reset low, bit 24 reads 1.
- R3: A reset after the first one leaves the delay, edge, swap and direction fields unchanged and keeps bit 24 at 1. It still clears the tap offset to 0 and the step-complete flag to 0.
- R4: A bus write updates the delay, edge, swap and direction fields, and the matching outputs, from the next clock edge. Data written to bits 25, 24, 20 and 19:0 has no effect.
- R5: A write with bit 23 set, accepted while no step is outstanding and bit 21 is 0, makes `ps_en_o` high for exactly the one cycle after the write. During that pulse `ps_dir_o` equals bit 22 of that write.
- R6: A `ps_done_i` pulse while a step is outstanding sets bit 21 from the next edge. A write with bit 21 = 0 clears the flag. A write with bit 21 = 1 never sets it. A `ps_done_i` with no step outstanding has no effect.
- R7: A step request made while a step is outstanding, or while bit 21 is 1, is dropped. No enable pulse follows, and the request is not held for later.
- R8: Each completed step changes the tap offset by +1 (increment) or −1 (decrement). The offset holds at +511 and at −512 instead of wrapping.
- R9: `rd_en_o` repeats `rd_en_i` delayed by exactly the programmed number of cycles, from 0 to 15. A delay of 0 passes the input through in the same cycle.
- R10: Bit 20 follows the `init_done_i` input.
- R11: If a completion pulse and a write clearing bit 21 land in the same cycle, the completion wins and bit 21 reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read-back of the register |
| init_done_i | input | 1 | Initialization-complete status from the controller |
| ps_en_o | output | 1 | One-cycle phase-step request to the phase shifter |
| ps_dir_o | output | 1 | Direction of the current step, 1 = increment |
| ps_done_i | input | 1 | Step-complete pulse from the phase shifter |
| rd_en_i | input | 1 | Raw read-enable pulse |
| rd_en_o | output | 1 | Delayed read-enable pulse toward the read FIFOs |
| rden_dly_o | output | 4 | Programmed read-enable delay |
| cap_rise_o | output | 1 | Capture-edge select, 1 = rising edge |
| half_swap_o | output | 1 | Half-cycle swap of double-rate read data |

## Verification
Two events can meet in one cycle: the phase shifter's completion pulse and a software write that clears the step-complete flag. The bench provokes this by driving `ps_done_i` and a clearing write in the same cycle. It then checks that bit 21 reads 1 and that the tap has moved. A second overlap is a new step request arriving in the same cycle as the completion of the previous step. That request must be dropped: the bench checks that no enable pulse follows and that the tap moves by only one.

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;

    localparam int DLY_W   = 4;
    localparam int TAP_W   = 10;
    localparam int TAP_OUT = 16;
    localparam int WORD_W  = 32;

    // Field bit k of the register sits on bus bit (WORD_W-1-k).
    function automatic int busbit(input int k);
        return WORD_W - 1 - k;
    endfunction

    localparam int B_DLY_HI = busbit(0);
    localparam int B_DLY_LO = busbit(3);
    localparam int B_RISE   = busbit(4);
    localparam int B_SWAP   = busbit(5);
    localparam int B_FIRST  = busbit(7);
    localparam int B_REQ    = busbit(8);
    localparam int B_DIR    = busbit(9);
    localparam int B_DONE   = busbit(10);
    localparam int B_INIT   = busbit(11);
    localparam int B_TAP_HI = busbit(16);
    localparam int B_TAP_LO = busbit(31);

    typedef logic signed [TAP_W-1:0] tap_t;

    localparam tap_t TAP_MAX = tap_t'({1'b0, {(TAP_W-1){1'b1}}});
    localparam tap_t TAP_MIN = tap_t'({1'b1, {(TAP_W-1){1'b0}}});

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             rise;
        logic             swap;
        logic             dir;
    } tune_t;

    typedef struct packed {
        logic en;
        logic dir;
        logic done;
        tap_t tap;
    } step_stat_t;

    function automatic tap_t tap_next(input tap_t t, input logic up);
        tap_t r;
        if (up) r = (t == TAP_MAX) ? t : t + tap_t'(1);
        else    r = (t == TAP_MIN) ? t : t - tap_t'(1);
        return r;
    endfunction

    function automatic logic [TAP_OUT-1:0] tap_sext(input tap_t t);
        return {{(TAP_OUT-TAP_W){t[TAP_W-1]}}, t};
    endfunction

endpackage

// File: rtl/phy_tune_bank.sv
module phy_tune_bank
    import phy_csr_pkg::*;
#(
    parameter int   RDEN_DLY_RST = 5,
    parameter logic RISE_RST     = 1'b1,
    parameter logic SWAP_RST     = 1'b0,
    parameter bit   HAS_DDR      = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_i,
    input  tune_t       wval_i,
    output tune_t       tune_o,
    output logic        first_done_o
);

    localparam tune_t TUNE_DEF = '{
        dly:  DLY_W'(RDEN_DLY_RST),
        rise: RISE_RST,
        swap: HAS_DDR ? SWAP_RST : 1'b0,
        dir:  1'b0
    };

    // Power-up value only; never cleared by reset afterwards.
    logic  first_q = 1'b0;
    tune_t tune_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (!first_q) tune_q <= TUNE_DEF;
        end else begin
            first_q <= 1'b1;
            if (wr_i) begin
                tune_q.dly  <= wval_i.dly;
                tune_q.rise <= wval_i.rise;
                tune_q.dir  <= wval_i.dir;
                tune_q.swap <= HAS_DDR ? wval_i.swap : 1'b0;
            end
        end
    end

    generate
        if (HAS_DDR) begin : g_ddr
            assign tune_o = tune_q;
        end else begin : g_sdr
            always_comb begin
                tune_o      = tune_q;
                tune_o.swap = 1'b0;
            end
        end
    endgenerate

    assign first_done_o = first_q;

endmodule

// File: rtl/phy_step_ctrl.sv
module phy_step_ctrl
    import phy_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       dir_i,
    input  logic       clr_i,
    input  logic       done_i,
    output step_stat_t stat_o
);

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} st_e;

    st_e  st_q;
    logic en_q;
    logic dir_q;
    tap_t tap_q;

    wire accept = req_i && (st_q == S_IDLE);
    wire finish = done_i && (st_q == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            en_q  <= 1'b0;
            dir_q <= 1'b0;
            tap_q <= '0;
        end else begin
            en_q <= accept;
            if (accept) dir_q <= dir_i;
            case (st_q)
                S_IDLE: if (accept) st_q <= S_WAIT;
                S_WAIT: if (finish) begin
                    st_q  <= S_DONE;
                    tap_q <= tap_next(tap_q, dir_q);
                end
                S_DONE: if (clr_i) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign stat_o = '{en: en_q, dir: dir_q, done: (st_q == S_DONE), tap: tap_q};

endmodule

// File: rtl/phy_rden_delay.sv
module phy_rden_delay
    import phy_csr_pkg::*;
#(
    parameter int SEL_W = DLY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             pulse_i,
    output logic             pulse_o
);

    localparam int DEPTH = (1 << SEL_W) - 1;

    logic [DEPTH:0] line;

    assign line[0] = pulse_i;

    generate
        for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
            logic stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= 1'b0;
                else     stg_q <= line[i-1];
            end
            assign line[i] = stg_q;
        end
    endgenerate

    assign pulse_o = line[sel_i];

endmodule

// File: rtl/phy_tune_csr.sv
module phy_tune_csr
    import phy_csr_pkg::*;
#(
    parameter int   RDEN_DLY_RST = 5,
    parameter logic RISE_RST     = 1'b1,
    parameter logic SWAP_RST     = 1'b0,
    parameter bit   HAS_DDR      = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        init_done_i,
    output logic        ps_en_o,
    output logic        ps_dir_o,
    input  logic        ps_done_i,
    input  logic        rd_en_i,
    output logic        rd_en_o,
    output logic [3:0]  rden_dly_o,
    output logic        cap_rise_o,
    output logic        half_swap_o
);

    tune_t      wval;
    tune_t      tune;
    logic       first_done;
    step_stat_t stat;

    always_comb begin
        wval.dly  = bus_wdata[B_DLY_HI:B_DLY_LO];
        wval.rise = bus_wdata[B_RISE];
        wval.swap = bus_wdata[B_SWAP];
        wval.dir  = bus_wdata[B_DIR];
    end

    phy_tune_bank #(
        .RDEN_DLY_RST (RDEN_DLY_RST),
        .RISE_RST     (RISE_RST),
        .SWAP_RST     (SWAP_RST),
        .HAS_DDR      (HAS_DDR)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .wr_i         (bus_we),
        .wval_i       (wval),
        .tune_o       (tune),
        .first_done_o (first_done)
    );

    phy_step_ctrl u_step (
        .clk    (clk),
        .rst    (rst),
        .req_i  (bus_we && bus_wdata[B_REQ]),
        .dir_i  (bus_wdata[B_DIR]),
        .clr_i  (bus_we && !bus_wdata[B_DONE]),
        .done_i (ps_done_i),
        .stat_o (stat)
    );

    phy_rden_delay #(.SEL_W(DLY_W)) u_dly (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (tune.dly),
        .pulse_i (rd_en_i),
        .pulse_o (rd_en_o)
    );

    always_comb begin
        bus_rdata                    = '0;
        bus_rdata[B_DLY_HI:B_DLY_LO] = tune.dly;
        bus_rdata[B_RISE]            = tune.rise;
        bus_rdata[B_SWAP]            = tune.swap;
        bus_rdata[B_FIRST]           = first_done;
        bus_rdata[B_REQ]             = stat.en;
        bus_rdata[B_DIR]             = tune.dir;
        bus_rdata[B_DONE]            = stat.done;
        bus_rdata[B_INIT]            = init_done_i;
        bus_rdata[B_TAP_HI:B_TAP_LO] = tap_sext(stat.tap);
    end

    assign ps_en_o     = stat.en;
    assign ps_dir_o    = stat.dir;
    assign rden_dly_o  = tune.dly;
    assign cap_rise_o  = tune.rise;
    assign half_swap_o = tune.swap;

endmodule

// File: rtl/phy_tune_csr_chk.sv
module phy_tune_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_we,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        ps_en_o,
    input logic        ps_done_i,
    input logic        rd_en_i,
    input logic        rd_en_o,
    input logic [3:0]  rden_dly_o
);

    logic        pend_q;
    logic [15:0] tap_prev_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else if (ps_en_o) pend_q <= 1'b1;
        else if (ps_done_i) pend_q <= 1'b0;
        tap_prev_q <= bus_rdata[15:0];
    end

    wire signed [16:0] tap_diff = $signed({bus_rdata[15], bus_rdata[15:0]})
                                - $signed({tap_prev_q[15], tap_prev_q});

    p_first_flag_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> bus_rdata[24]);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        ps_en_o |=> !ps_en_o);

    p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rdata[21]) |-> $past(ps_done_i));

    p_drop_req_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_wdata[23] && (pend_q || ps_en_o || bus_rdata[21])) |=> !ps_en_o);

    p_tap_step_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tap_diff >= -17'sd1 && tap_diff <= 17'sd1));

    p_pass_through_r9: assert property (@(posedge clk) disable iff (rst)
        (rden_dly_o == 4'd0) |-> (rd_en_o == rd_en_i));

endmodule

bind phy_tune_csr phy_tune_csr_chk u_chk (.*);

// File: tb/phy_tune_csr_test.sv
module phy_tune_csr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        init_done_i = 1'b0;
    logic        ps_en_o, ps_dir_o;
    logic        ps_done_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        rd_en_o;
    logic [3:0]  rden_dly_o;
    logic        cap_rise_o, half_swap_o;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    int s_dly = 5;
    bit s_rise = 1, s_swap = 0, s_dir = 0;
    int model_tap = 0;

    always #10 clk = ~clk;

    phy_tune_csr uut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit req, input bit dk, input logic [31:0] junk);
        logic [31:0] w = junk;
        w[31:28] = 4'(s_dly);
        w[27] = s_rise;
        w[26] = s_swap;
        w[23] = req;
        w[22] = s_dir;
        w[21] = dk;
        return w;
    endfunction

    function automatic int tap_rd();
        return int'($signed(bus_rdata[15:0]));
    endfunction

    function automatic int tap_model(input int t, input bit up);
        if (up) return (t == 511) ? t : t + 1;
        return (t == -512) ? t : t - 1;
    endfunction

    task automatic wr(input logic [31:0] w);
        bus_we = 1'b1;
        bus_wdata = w;
        tick();
        bus_we = 1'b0;
        bus_wdata = $urandom;
    endtask

    task automatic chk_fields(input string req);
        chk({req, " dly"}, int'(rden_dly_o), s_dly);
        chk({req, " dly rb"}, int'(bus_rdata[31:28]), s_dly);
        chk({req, " rise"}, int'(cap_rise_o), int'(s_rise));
        chk({req, " swap"}, int'(half_swap_o), int'(s_swap));
        chk({req, " dir rb"}, int'(bus_rdata[22]), int'(s_dir));
    endtask

    task automatic do_step(input bit up, input bit full);
        s_dir = up;
        wr(mk(1'b1, 1'b0, 32'h0));
        if (full) begin
            chk("R5 en", int'(ps_en_o), 1);
            chk("R5 dir", int'(ps_dir_o), int'(up));
        end
        tick();
        if (full) chk("R5 one cycle", int'(ps_en_o), 0);
        ps_done_i = 1'b1;
        tick();
        ps_done_i = 1'b0;
        model_tap = tap_model(model_tap, up);
        chk("R8 tap", tap_rd(), model_tap);
        if (full) chk("R6 done set", int'(bus_rdata[21]), 1);
        wr(mk(1'b0, 1'b0, 32'h0));
        if (full) chk("R6 done cleared", int'(bus_rdata[21]), 0);
    endtask

    initial begin
        #(20ns * 150000);
        if (!ended) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // first reset
        tick(); tick();
        chk("R2 first flag in reset", int'(bus_rdata[24]), 0);
        chk_fields("R2 default");
        chk("R8 tap reset", tap_rd(), 0);
        rst = 1'b0;
        tick();
        chk("R2 first flag after", int'(bus_rdata[24]), 1);

        // random field writes, junk in read-only bits
        for (int i = 0; i < 30; i++) begin
            logic [31:0] junk = $urandom;
            s_dly  = int'($urandom % 16);
            s_rise = 1'($urandom);
            s_swap = 1'($urandom);
            s_dir  = 1'($urandom);
            init_done_i = 1'($urandom);
            wr(mk(1'b0, 1'b1, junk));
            chk_fields("R4 write");
            chk("R1 bit25 zero", int'(bus_rdata[25]), 0);
            chk("R1 bits19:16 zero", int'(bus_rdata[19:16]), 0);
            chk("R4 first flag kept", int'(bus_rdata[24]), 1);
            chk("R6 write1 no set", int'(bus_rdata[21]), 0);
            chk("R4 tap untouched", tap_rd(), 0);
            chk("R10 init", int'(bus_rdata[20]), int'(init_done_i));
        end

        // stray done with nothing outstanding
        ps_done_i = 1'b1; tick(); ps_done_i = 1'b0;
        chk("R6 stray done", int'(bus_rdata[21]), 0);
        chk("R6 stray tap", tap_rd(), 0);

        // directed steps
        do_step(1'b1, 1'b1);
        do_step(1'b1, 1'b1);
        do_step(1'b0, 1'b1);

        // request while outstanding and while done set
        s_dir = 1'b1;
        wr(mk(1'b1, 1'b0, 32'h0));
        chk("R5 en", int'(ps_en_o), 1);
        wr(mk(1'b1, 1'b0, 32'h0));
        chk("R7 busy drop", int'(ps_en_o), 0);
        ps_done_i = 1'b1;
        bus_we = 1'b1; bus_wdata = mk(1'b1, 1'b1, 32'h0);
        tick();
        ps_done_i = 1'b0; bus_we = 1'b0;
        model_tap = tap_model(model_tap, 1'b1);
        chk("R7 drop at finish", int'(ps_en_o), 0);
        chk("R8 single move", tap_rd(), model_tap);
        wr(mk(1'b1, 1'b1, 32'h0));
        chk("R7 done-set drop", int'(ps_en_o), 0);
        tick();
        chk("R7 not queued", int'(ps_en_o), 0);
        wr(mk(1'b0, 1'b0, 32'h0));

        // collision: completion and clearing write together
        wr(mk(1'b1, 1'b0, 32'h0));
        tick();
        ps_done_i = 1'b1;
        bus_we = 1'b1; bus_wdata = mk(1'b0, 1'b0, 32'h0);
        tick();
        ps_done_i = 1'b0; bus_we = 1'b0;
        model_tap = tap_model(model_tap, s_dir);
        chk("R11 done wins", int'(bus_rdata[21]), 1);
        chk("R11 tap", tap_rd(), model_tap);
        wr(mk(1'b0, 1'b0, 32'h0));

        // random steps
        for (int i = 0; i < 40; i++) do_step(1'($urandom), 1'b0);

        // later reset keeps tuning
        s_dly = 9; s_rise = 0; s_swap = 1; s_dir = 1;
        wr(mk(1'b0, 1'b0, 32'h0));
        rst = 1'b1; tick(); tick();
        chk("R3 flag in reset", int'(bus_rdata[24]), 1);
        rst = 1'b0; tick();
        model_tap = 0;
        chk_fields("R3 kept");
        chk("R3 tap cleared", tap_rd(), 0);
        chk("R3 done cleared", int'(bus_rdata[21]), 0);

        // saturation
        while (model_tap < 511) do_step(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) do_step(1'b1, 1'b0);
        chk("R8 hold max", tap_rd(), 511);
        chk("R1 sign ext pos", int'(bus_rdata[15:10]), 0);
        while (model_tap > -512) do_step(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) do_step(1'b0, 1'b0);
        chk("R8 hold min", tap_rd(), -512);
        chk("R1 sign ext neg", int'(bus_rdata[15:10]), 63);

        // read-enable delay line
        for (int d = 0; d < 16; d++) begin
            s_dly = d;
            wr(mk(1'b0, 1'b0, 32'h0));
            for (int k = 0; k < 18; k++) tick();
            rd_en_i = 1'b1;
            #1;
            chk("R9 cycle 0", int'(rd_en_o), (d == 0) ? 1 : 0);
            tick();
            rd_en_i = 1'b0;
            #1;
            for (int k = 1; k <= 16; k++) begin
                chk("R9 cycle k", int'(rd_en_o), (k == d) ? 1 : 0);
                tick();
            end
        end

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule